// File: doc/BRIEF.md
# Serial Transfer Status Flag Unit

This unit holds the status and error flags of a half-duplex serial character port. It sits between a character engine and a CPU register port. The character engine moves bits on the wire and reports character-level events as strobes. The unit keeps a one-character transmit holding buffer and a one-character receive holding buffer. It also watches the RX line itself and reports a break when the line stays low for longer than one whole character.

The CPU reaches the unit through two registers selected by `cpu_addr`. Address 0 is the data register: a write fills the TX holding buffer, and a read returns the RX holding buffer. Address 1 is the status register: a read returns the eight flags, and a write clears error flags wherever a 0 is written. A flag rises only from a hardware event, and a hardware set in the same cycle as a software clear wins. The character length, the parity mode and the stop-bit count are parameters. The break timer counts in bit times, using an enable input.

Top module: `sxfer_flags`

## Requirements
- R1: The status byte has the layout bit7 activity, bit6 break, bit5 frame error, bit4 parity error, bit3 TX empty, bit2 TX overflow, bit1 RX empty, bit0 RX overflow. After a synchronous reset it reads 8'h0A.
- R2: Bit7 equals the OR of `tx_busy` and `rx_busy` as sampled at the previous clock edge. Writing the status register does not change it.
- R3: One character time is CHAR_BITS = 1 + DATA_W + PAR_EN + STOP_BITS bit ticks, which is 11 with the defaults. Bit6 sets on the (CHAR_BITS+1)-th `bit_tick` seen while `rx_line` is continuously 0. Any cycle with `rx_line` at 1 restarts the count, so a low run of only CHAR_BITS ticks leaves bit6 clear.
- R4: An `rx_done` strobe with `rx_stop_bit` = 0 sets bit5.
- R5: With PAR_EN = 1, an `rx_done` strobe whose `rx_par_bit` differs from the XOR of `rx_data` (inverted when PAR_ODD = 1) sets bit4.
- R6: A data write (address 0) while bit3 = 1 stores the byte on `tx_hold_data` and clears bit3. A `tx_load` strobe sets bit3 again. `tx_hold_full` is the inverse of bit3.
- R7: A data write while bit3 = 0 sets bit2 and leaves `tx_hold_data` unchanged.
- R8: An `rx_done` strobe clears bit1 and stores `rx_data` when the buffer is free. A data read (address 0 with `cpu_rd`) returns the buffered byte on `cpu_rdata` in the same cycle and sets bit1.
- R9: An `rx_done` strobe while bit1 = 0 and no data read is in progress sets bit0 and keeps the previous byte. An `rx_done` in the same cycle as a data read stores the new byte and does not set bit0.
- R10: Writing the status register clears each of bits 6, 5, 4, 2 and 0 that is written as 0. Writing a 1 has no effect. Bits 7, 3 and 1 ignore status writes.
- R11: When a hardware set event and a status-write clear of the same flag fall in one cycle, the flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle enable per bit time, for the break timer |
| rx_line | input | 1 | Receive line level, already synchronous to clk |
| tx_busy | input | 1 | Engine is shifting a transmit character |
| rx_busy | input | 1 | Engine is receiving a character |
| tx_load | input | 1 | Engine took the holding buffer into its shift register |
| rx_done | input | 1 | Engine completed a received character |
| rx_data | input | DATA_W | Received character bits |
| rx_par_bit | input | 1 | Parity bit as sampled by the engine |
| rx_stop_bit | input | 1 | Stop-position bit as sampled by the engine |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (side effect only on address 0) |
| cpu_addr | input | 1 | 0 = data register, 1 = status register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed register, combinational |
| tx_hold_data | output | DATA_W | Content of the TX holding buffer |
| tx_hold_full | output | 1 | TX holding buffer holds an unsent byte |

## Verification
Every flag and both holding buffers are registers. Each result is therefore due one clock after the edge that sees its stimulus, while `cpu_rdata` follows the address and the stored state in the same cycle. The bench drives inputs at the falling edge, drops strobes half a nanosecond after the next rising edge, and samples one nanosecond after that edge. At that point the flags reflect exactly that one stimulus. A data-read value is sampled before the rising edge, while the read strobe is still high. Break detection is checked tick by tick, on both sides of the (CHAR_BITS+1)-th tick.

// File: rtl/sxfer_flags_pkg.sv
package sxfer_flags_pkg;

    localparam int STAT_W = 8;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_STAT = 1'b1
    } reg_sel_e;

    // Status byte, MSB first; this order is the software-visible layout.
    typedef struct packed {
        logic act;
        logic brk;
        logic frm;
        logic par;
        logic txe;
        logic txov;
        logic rxe;
        logic rxov;
    } stat_t;

    localparam stat_t STAT_RST = '{act: 1'b0, brk: 1'b0, frm: 1'b0, par: 1'b0,
                                   txe: 1'b1, txov: 1'b0, rxe: 1'b1, rxov: 1'b0};

    // Sticky error flags, cleared by software.
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic txov;
        logic rxov;
    } err_t;

    function automatic int char_bits(input int dw, input int pe, input int sb);
        return 1 + dw + pe + sb;
    endfunction

    // A set event beats a write-zero clear; writing one keeps the flag.
    function automatic logic sticky_next(input logic cur, input logic set,
                                         input logic wr, input logic wbit);
        return set | (cur & ~(wr & ~wbit));
    endfunction

endpackage

// File: rtl/sxfer_break_timer.sv
module sxfer_break_timer #(
    parameter int CHAR_BITS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic rx_line,
    output logic brk_hit
);
    localparam int LIM = CHAR_BITS + 1;
    localparam int CW  = $clog2(LIM + 1);
    localparam logic [CW-1:0] LIM_V  = CW'(LIM);
    localparam logic [CW-1:0] FULL_V = CW'(CHAR_BITS);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || rx_line) begin
            low_cnt <= '0;
        end else if (bit_tick && (low_cnt != LIM_V)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Fires once per low run, on the tick that exceeds one character time.
    assign brk_hit = bit_tick && !rx_line && (low_cnt == FULL_V);

endmodule

// File: rtl/sxfer_tx_hold.sv
module sxfer_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_load,
    output logic              txe,
    output logic              txov_set,
    output logic [DATA_W-1:0] hold_data
);
    logic accept;

    assign accept   = wr_en && txe;
    assign txov_set = wr_en && !txe;

    always_ff @(posedge clk) begin
        if (rst) begin
            txe       <= 1'b1;
            hold_data <= '0;
        end else begin
            if (accept) begin
                hold_data <= wdata;
            end
            if (tx_load) begin
                txe <= 1'b1;
            end else if (accept) begin
                txe <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sxfer_rx_hold.sv
module sxfer_rx_hold #(
    parameter int DATA_W  = 8,
    parameter bit PAR_EN  = 1'b1,
    parameter bit PAR_ODD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_bit,
    input  logic              rx_stop_bit,
    output logic              rxe,
    output logic [DATA_W-1:0] rx_buf,
    output logic              frm_set,
    output logic              par_set,
    output logic              rxov_set
);
    logic free;
    logic store;

    assign free     = rxe || rd_en;
    assign store    = rx_done && free;
    assign rxov_set = rx_done && !free;
    assign frm_set  = rx_done && !rx_stop_bit;

    generate
        if (PAR_EN) begin : g_par
            logic want;
            assign want    = (^rx_data) ^ PAR_ODD;
            assign par_set = rx_done && (rx_par_bit != want);
        end else begin : g_nopar
            assign par_set = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rxe    <= 1'b1;
            rx_buf <= '0;
        end else begin
            if (store) begin
                rx_buf <= rx_data;
            end
            if (rx_done) begin
                rxe <= 1'b0;
            end else if (rd_en) begin
                rxe <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sxfer_flags.sv
module sxfer_flags
    import sxfer_flags_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter bit PAR_EN    = 1'b1,
    parameter bit PAR_ODD   = 1'b0,
    parameter int STOP_BITS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              rx_line,
    input  logic              tx_busy,
    input  logic              rx_busy,
    input  logic              tx_load,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_bit,
    input  logic              rx_stop_bit,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic [DATA_W-1:0] tx_hold_data,
    output logic              tx_hold_full
);
    localparam int CHAR_BITS = char_bits(DATA_W, int'(PAR_EN), STOP_BITS);

    reg_sel_e    sel;
    logic        wr_dat, wr_stat, rd_dat;
    logic        brk_hit, txov_set, frm_set, par_set, rxov_set;
    logic        txe, rxe, act_q;
    logic [DATA_W-1:0] rx_buf;
    err_t        err_q, err_set;
    stat_t       stat;
    logic [STAT_W-1:0] stat_q;
    stat_t       wbits;

    assign sel     = reg_sel_e'(cpu_addr);
    assign wr_dat  = cpu_wr && (sel == REG_DATA);
    assign wr_stat = cpu_wr && (sel == REG_STAT);
    assign rd_dat  = cpu_rd && (sel == REG_DATA);
    assign wbits   = stat_t'(cpu_wdata);

    sxfer_break_timer #(.CHAR_BITS(CHAR_BITS)) u_brk (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .rx_line  (rx_line),
        .brk_hit  (brk_hit)
    );

    sxfer_tx_hold #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_dat),
        .wdata     (cpu_wdata[DATA_W-1:0]),
        .tx_load   (tx_load),
        .txe       (txe),
        .txov_set  (txov_set),
        .hold_data (tx_hold_data)
    );

    sxfer_rx_hold #(.DATA_W(DATA_W), .PAR_EN(PAR_EN), .PAR_ODD(PAR_ODD)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_dat),
        .rx_done     (rx_done),
        .rx_data     (rx_data),
        .rx_par_bit  (rx_par_bit),
        .rx_stop_bit (rx_stop_bit),
        .rxe         (rxe),
        .rx_buf      (rx_buf),
        .frm_set     (frm_set),
        .par_set     (par_set),
        .rxov_set    (rxov_set)
    );

    assign err_set = '{brk: brk_hit, frm: frm_set, par: par_set,
                       txov: txov_set, rxov: rxov_set};

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            act_q <= 1'b0;
        end else begin
            act_q      <= tx_busy || rx_busy;
            err_q.brk  <= sticky_next(err_q.brk,  err_set.brk,  wr_stat, wbits.brk);
            err_q.frm  <= sticky_next(err_q.frm,  err_set.frm,  wr_stat, wbits.frm);
            err_q.par  <= sticky_next(err_q.par,  err_set.par,  wr_stat, wbits.par);
            err_q.txov <= sticky_next(err_q.txov, err_set.txov, wr_stat, wbits.txov);
            err_q.rxov <= sticky_next(err_q.rxov, err_set.rxov, wr_stat, wbits.rxov);
        end
    end

    always_comb begin
        stat      = STAT_RST;
        stat.act  = act_q;
        stat.brk  = err_q.brk;
        stat.frm  = err_q.frm;
        stat.par  = err_q.par;
        stat.txe  = txe;
        stat.txov = err_q.txov;
        stat.rxe  = rxe;
        stat.rxov = err_q.rxov;
    end

    assign stat_q       = stat;
    assign tx_hold_full = !txe;

    always_comb begin
        cpu_rdata = '0;
        if (sel == REG_STAT) begin
            cpu_rdata = stat_q;
        end else begin
            cpu_rdata[DATA_W-1:0] = rx_buf;
        end
    end

endmodule

// File: rtl/sxfer_flags_chk.sv
module sxfer_flags_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_busy,
    input logic              rx_busy,
    input logic              rx_done,
    input logic              rx_stop_bit,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic              cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic [7:0]        stat,
    input logic [DATA_W-1:0] rx_buf
);
    localparam logic [7:0] ERR_M = 8'h75;

    AST_RESET_VALUE: assert property (@(posedge clk)
        rst |=> (stat == 8'h0A)); // R1

    AST_ACT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (tx_busy || rx_busy) |=> stat[7]); // R2

    AST_ACT_LOW: assert property (@(posedge clk) disable iff (rst)
        !(tx_busy || rx_busy) |=> !stat[7]); // R2

    AST_FRAME_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !rx_stop_bit) |=> stat[5]); // R4

    AST_TX_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_addr && !stat[3]) |=> stat[2]); // R7

    AST_RX_FILLED: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !stat[1]); // R8

    AST_RX_OVERFLOW_KEEP: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !stat[1] && !(cpu_rd && !cpu_addr)) |=> (stat[0] && $stable(rx_buf))); // R9

    AST_WRITE_ONE_NOOP: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr && (cpu_wdata == 8'hFF))
            |=> ((stat & ERR_M & $past(stat & ERR_M)) == $past(stat & ERR_M))); // R10

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !rx_stop_bit && cpu_wr && cpu_addr && !cpu_wdata[5]) |=> stat[5]); // R11

endmodule

bind sxfer_flags sxfer_flags_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_busy     (tx_busy),
    .rx_busy     (rx_busy),
    .rx_done     (rx_done),
    .rx_stop_bit (rx_stop_bit),
    .cpu_wr      (cpu_wr),
    .cpu_rd      (cpu_rd),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .stat        (stat_q),
    .rx_buf      (rx_buf)
);

// File: tb/sxfer_flags_tb.sv
`timescale 1ns/100ps
module sxfer_flags_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0, rx_line = 1'b1;
    logic       tx_busy = 1'b0, rx_busy = 1'b0, tx_load = 1'b0, rx_done = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_par_bit = 1'b0, rx_stop_bit = 1'b1;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_addr = 1'b1;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [7:0] tx_hold_data;
    logic       tx_hold_full;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sxfer_flags u_dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_line(rx_line),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .tx_load(tx_load), .rx_done(rx_done),
        .rx_data(rx_data), .rx_par_bit(rx_par_bit), .rx_stop_bit(rx_stop_bit),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .tx_hold_data(tx_hold_data), .tx_hold_full(tx_hold_full)
    );

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic       addr;
        logic [7:0] wd;
        logic       txl;
        logic       rxd;
        logic [7:0] rxdat;
        logic       par;
        logic       stop;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h02, 4'd6},  // R6 write fills TX
        '{1'b1, 1'b0, 1'b0, 8'h33, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h06, 4'd7},  // R7 write while full
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h0E, 4'd6},  // R6 tx_load
        '{1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h0A, 4'd10}, // R10 clear all
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1, 8'h08, 4'd8},  // R8 good char
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h07, 1'b0, 1'b0, 8'h39, 4'd9},  // R4 R5 R9
        '{1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h3B, 4'd8},  // R8 data read
        '{1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h3B, 4'd10}, // R10 ones no-op
        '{1'b1, 1'b0, 1'b1, 8'hEF, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h2B, 4'd10}, // R10 clear parity
        '{1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h0A, 4'd10}  // R10 clear rest
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic addr, input logic [7:0] wd,
                        input logic txl, input logic rxd, input logic [7:0] rxdat,
                        input logic par, input logic stop);
        @(negedge clk);
        cpu_wr = wr; cpu_rd = rd; cpu_addr = addr; cpu_wdata = wd;
        tx_load = txl; rx_done = rxd; rx_data = rxdat; rx_par_bit = par; rx_stop_bit = stop;
        @(posedge clk);
        #0.5;
        cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = 1'b1; tx_load = 1'b0; rx_done = 1'b0;
        rx_stop_bit = 1'b1;
        #0.5;
    endtask

    task automatic tick();
        @(negedge clk);
        bit_tick = 1'b1;
        @(posedge clk);
        #0.5 bit_tick = 1'b0;
        #0.5;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1 check(cpu_rdata, 8'h0A, "R1 reset status");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, VEC[i].rd, VEC[i].addr, VEC[i].wd, VEC[i].txl, VEC[i].rxd,
                 VEC[i].rxdat, VEC[i].par, VEC[i].stop);
            check(cpu_rdata, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
        end

        // R1: reset from a dirty state
        step(1'b1, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        #1 check(cpu_rdata, 8'h0A, "R1 reset after activity");

        // R6 / R7: holding buffer contents
        step(1'b1, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        check({tx_hold_full, 7'd0}, 8'h80, "R6 hold full");
        check(tx_hold_data, 8'h5A, "R6 hold data");
        step(1'b1, 1'b0, 1'b0, 8'h33, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        check(tx_hold_data, 8'h5A, "R7 hold kept on overflow");
        step(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
        check({tx_hold_full, 7'd0}, 8'h00, "R6 hold emptied");
        step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);

        // R2: activity
        @(negedge clk) tx_busy = 1'b1;
        @(posedge clk); #1 check(cpu_rdata & 8'h80, 8'h80, "R2 activity on");
        step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        check(cpu_rdata & 8'h80, 8'h80, "R2 activity ignores write");
        @(negedge clk) begin tx_busy = 1'b0; rx_busy = 1'b1; end
        @(negedge clk) rx_busy = 1'b0;
        @(posedge clk); #1 check(cpu_rdata & 8'h80, 8'h00, "R2 activity off");
        step(1'b1, 1'b0, 1'b1, 8'h80, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        check(cpu_rdata, 8'h0A, "R10 read-only bits ignore write");

        // R3: break timing
        @(negedge clk) rx_line = 1'b0;
        for (int k = 0; k < 11; k++) tick();
        check(cpu_rdata & 8'h40, 8'h00, "R3 no break at one character");
        tick();
        check(cpu_rdata & 8'h40, 8'h40, "R3 break past one character");
        @(negedge clk) rx_line = 1'b1;
        step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        check(cpu_rdata, 8'h0A, "R10 break cleared");
        @(negedge clk) rx_line = 1'b0;
        for (int k = 0; k < 11; k++) tick();
        @(negedge clk) rx_line = 1'b1;
        @(negedge clk) rx_line = 1'b0;
        for (int k = 0; k < 11; k++) tick();
        check(cpu_rdata & 8'h40, 8'h00, "R3 high level restarts count");
        @(negedge clk) rx_line = 1'b1;

        // R11 / R4: set beats clear
        step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
        check(cpu_rdata & 8'h20, 8'h20, "R11 frame set wins over clear");

        // R8 / R9: overflow keeps old byte
        @(negedge clk) begin cpu_addr = 1'b0; cpu_rd = 1'b1; end
        #1 check(cpu_rdata, 8'h00, "R8 read returns buffered byte");
        @(posedge clk); #0.5 begin cpu_rd = 1'b0; cpu_addr = 1'b1; end
        step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h11, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 8'h22, 1'b0, 1'b1);
        check(cpu_rdata, 8'h09, "R9 overflow flag");
        @(negedge clk) cpu_addr = 1'b0;
        #1 check(cpu_rdata, 8'h11, "R9 old byte kept");
        step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);

        // R9: arrival during a read is not an overflow
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 8'h55, 1'b0, 1'b1);
        check(cpu_rdata, 8'h08, "R9 no overflow when read frees buffer");
        @(negedge clk) cpu_addr = 1'b0;
        #1 check(cpu_rdata, 8'h55, "R8 new byte stored");
        idle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule